// File: doc/BRIEF.md
# Directory Home Node Controller

This block is the home side of a directory coherence scheme for the blocks of one memory bank. For every block it holds a presence vector with one bit per processor and a dirty flag, plus the block's data word. Processors send it read requests and write-ownership requests. It answers from memory when it can. Otherwise it first sends invalidations to the other sharers or recalls the line from the processor that holds it modified, and only then replies to the requester.

While it waits for invalidation acknowledgements, the block is in a transient shared state. While it waits for the owner's write-back, the block is in a transient owned state. The controller handles one transaction at a time. It lowers its request ready signal from acceptance until the final reply is taken, so a request aimed at a transient block is held back by the sender. Outgoing messages go out one per cycle under a valid/ready handshake. Each carries a type, the block address, the destination processor id and a data word. Incoming responses are always accepted. The network is assumed reliable and in order for each source and destination pair.

Top module: `dir_home`

## Requirements
- R1: After reset, `reqReady` is 1, `outValid` is 0, every presence vector and dirty flag is clear, and block b holds the data value b.
- R2: A read (`reqWrite`=0) of a clean block is answered by one shared-data reply (type 3) to the requester. It carries the block address and the memory word, and the requester's presence bit is set. Every message a transaction emits carries that transaction's block address, and every reply (types 3, 4, 5) goes to the requester.
- R3: A write (`reqWrite`=1) to a clean block first sends one invalidation (type 0) to each processor whose presence bit is set, other than the requester. They go out in ascending processor id, one per accepted handshake.
- R4: The exclusive-data reply (type 4) after invalidations appears only after one acknowledgement (`rspWb`=0, matching address, source among the invalidated) per invalidation sent. Afterwards the requester is the sole holder and the block is dirty.
- R5: A read of a block held modified by another processor sends a downgrade recall (type 1) to the owner. On the owner's write-back (`rspWb`=1), memory takes `rspData` and the requester gets a shared-data reply with that word. The block is then clean and shared by the old owner and the requester.
- R6: A write to a block held modified by another processor sends an invalidating recall (type 2) to the owner. On its write-back, memory is updated and the requester gets an exclusive-data reply with the written-back word. The requester is then the only holder.
- R7: A read or write from the processor that already holds the block modified is answered at once with a grant (type 5) carrying the memory word. No other message is sent and the directory is unchanged.
- R8: `reqReady` is 0 from the cycle after a request is accepted until the cycle after its final reply is taken.
- R9: While `outValid` is 1 and `outReady` is 0, the outgoing message stays valid and unchanged.
- R10: A response with the wrong address, the wrong kind, or a source that is not the awaited owner or an invalidated sharer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write-ownership request, 0 = read |
| reqAddr | input | ADDR_W | Block index |
| reqSrc | input | ID_W | Requesting processor id |
| rspValid | input | 1 | Cache response present |
| rspWb | input | 1 | 1 = write-back data, 0 = invalidation acknowledgement |
| rspAddr | input | ADDR_W | Block index of the response |
| rspSrc | input | ID_W | Responding processor id |
| rspData | input | DATA_W | Write-back data |
| outValid | output | 1 | Outgoing message present |
| outReady | input | 1 | Network takes the message |
| outType | output | 3 | 0 inval, 1 downgrade recall, 2 invalidating recall, 3 shared data, 4 exclusive data, 5 grant |
| outAddr | output | ADDR_W | Block index |
| outDest | output | ID_W | Destination processor id |
| outData | output | DATA_W | Memory word of the block |

## Verification
The bench builds a block with three sharers and checks that the writer is left out of the invalidation set and that the others are hit in ascending order. If the requester's own bit were kept, an extra invalidation would go to the writer and the acknowledgement count would never finish. Acknowledgements for the wrong block or from a non-target are mixed in. A controller that counted them would reply early, which the bench sees as a valid message while acknowledgements are still owed. During a recall, a write-back from the wrong processor is injected. A design that took it would reply with foreign data or move on too early. The bench also holds back `outReady` mid-stream and revisits blocks after ownership changes. A wrong sharer update then shows up as a missing or misdirected recall or invalidation.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;

  typedef enum logic [2:0] {
    MSG_INV        = 3'd0,
    MSG_RECALL_SH  = 3'd1,
    MSG_RECALL_INV = 3'd2,
    MSG_DATA_SH    = 3'd3,
    MSG_DATA_EX    = 3'd4,
    MSG_GRANT      = 3'd5
  } msg_e;

  typedef struct packed {
    logic latchReq;
    logic loadInv;
    logic popInv;
    logic countAck;
    logic captureWb;
    logic commitShared;
    logic commitExcl;
  } dir_strobe_t;

endpackage

// File: rtl/dir_home_dpath.sv
module dir_home_dpath
  import dir_home_pkg::*;
#(
  parameter int NUM_PROC   = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 3,
  parameter int ID_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dir_strobe_t       strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ID_W-1:0]   reqSrc,
  input  logic              rspValid,
  input  logic              rspWb,
  input  logic [ADDR_W-1:0] rspAddr,
  input  logic [ID_W-1:0]   rspSrc,
  input  logic [DATA_W-1:0] rspData,
  input  msg_e              msgType,
  output logic [ADDR_W-1:0] outAddr,
  output logic [ID_W-1:0]   outDest,
  output logic [DATA_W-1:0] outData,
  output logic              curWrite,
  output logic              curDirty,
  output logic              ownerIsReq,
  output logic              othersEmpty,
  output logic              lastInv,
  output logic              acksDone,
  output logic              wbHit
);

  localparam int CNT_W = $clog2(NUM_PROC + 1);

  logic [NUM_PROC-1:0] presence [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] dirty;
  logic [DATA_W-1:0]   mem [NUM_BLOCKS];

  logic [ADDR_W-1:0]   curAddr;
  logic [ID_W-1:0]     curSrc;
  logic                curWriteQ;
  logic [NUM_PROC-1:0] pendInv;
  logic [NUM_PROC-1:0] invTarget;
  logic [CNT_W-1:0]    ackCnt;

  logic [NUM_PROC-1:0] srcMask;
  logic [NUM_PROC-1:0] curPres;
  logic [NUM_PROC-1:0] others;
  logic [ID_W-1:0]     ownerId;
  logic [ID_W-1:0]     nextInvId;
  logic                ackHit;

  function automatic logic [ID_W-1:0] firstSet(input logic [NUM_PROC-1:0] v);
    logic [ID_W-1:0] idx;
    idx = '0;
    for (int i = NUM_PROC - 1; i >= 0; i--) begin
      if (v[i]) idx = ID_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [CNT_W-1:0] countSet(input logic [NUM_PROC-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < NUM_PROC; i++) begin
      n = n + CNT_W'(v[i]);
    end
    return n;
  endfunction

  assign srcMask   = NUM_PROC'(1) << curSrc;
  assign curPres   = presence[curAddr];
  assign others    = curPres & ~srcMask;
  assign ownerId   = firstSet(curPres);
  assign nextInvId = firstSet(pendInv);

  assign curWrite    = curWriteQ;
  assign curDirty    = dirty[curAddr];
  assign ownerIsReq  = dirty[curAddr] && curPres[curSrc];
  assign othersEmpty = (others == '0);
  assign lastInv     = ((pendInv & (pendInv - 1'b1)) == '0);
  assign acksDone    = (ackCnt == '0);
  assign wbHit       = rspValid && rspWb && (rspAddr == curAddr) && (rspSrc == ownerId);
  assign ackHit      = rspValid && !rspWb && (rspAddr == curAddr) &&
                       invTarget[rspSrc] && (ackCnt != '0);

  always_comb begin
    unique case (msgType)
      MSG_INV:                        outDest = nextInvId;
      MSG_RECALL_SH, MSG_RECALL_INV:  outDest = ownerId;
      default:                        outDest = curSrc;
    endcase
  end

  assign outAddr = curAddr;
  assign outData = mem[curAddr];

  // Request register and invalidation bookkeeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      curSrc    <= '0;
      curWriteQ <= 1'b0;
      pendInv   <= '0;
      invTarget <= '0;
      ackCnt    <= '0;
    end else begin
      if (strobe.latchReq) begin
        curAddr   <= reqAddr;
        curSrc    <= reqSrc;
        curWriteQ <= reqWrite;
      end
      if (strobe.loadInv) begin
        pendInv   <= others;
        invTarget <= others;
        ackCnt    <= countSet(others);
      end else begin
        if (strobe.popInv) pendInv <= pendInv & (pendInv - 1'b1);
        if (strobe.countAck && ackHit) ackCnt <= ackCnt - 1'b1;
      end
    end
  end

  // Directory and memory array
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirty <= '0;
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        presence[b] <= '0;
        mem[b]      <= DATA_W'(b);
      end
    end else begin
      if (strobe.captureWb) mem[curAddr] <= rspData;
      if (strobe.commitShared) begin
        presence[curAddr] <= curPres | srcMask;
        dirty[curAddr]    <= 1'b0;
      end else if (strobe.commitExcl) begin
        presence[curAddr] <= srcMask;
        dirty[curAddr]    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_home_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        curWrite,
  input  logic        curDirty,
  input  logic        ownerIsReq,
  input  logic        othersEmpty,
  input  logic        lastInv,
  input  logic        acksDone,
  input  logic        wbHit,
  output logic        outValid,
  input  logic        outReady,
  output msg_e        msgType,
  output dir_strobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_SEND_INV, ST_WAIT_ACK,
    ST_SEND_RECALL, ST_WAIT_WB, ST_REPLY
  } state_e;

  state_e state, stateNext;
  msg_e   replyKind, replyNext;
  msg_e   recallKind, recallNext;

  always_comb begin
    stateNext  = state;
    replyNext  = replyKind;
    recallNext = recallKind;
    strobe     = '0;
    reqReady   = (state == ST_IDLE);
    outValid   = 1'b0;
    msgType    = replyKind;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          stateNext       = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (ownerIsReq) begin
          replyNext = MSG_GRANT;
          stateNext = ST_REPLY;
        end else if (!curWrite && !curDirty) begin
          replyNext = MSG_DATA_SH;
          stateNext = ST_REPLY;
        end else if (curDirty) begin
          recallNext = curWrite ? MSG_RECALL_INV : MSG_RECALL_SH;
          replyNext  = curWrite ? MSG_DATA_EX : MSG_DATA_SH;
          stateNext  = ST_SEND_RECALL;
        end else begin
          strobe.loadInv = 1'b1;
          replyNext      = MSG_DATA_EX;
          stateNext      = othersEmpty ? ST_REPLY : ST_SEND_INV;
        end
      end
      ST_SEND_INV: begin
        outValid        = 1'b1;
        msgType         = MSG_INV;
        strobe.countAck = 1'b1;
        if (outReady) begin
          strobe.popInv = 1'b1;
          if (lastInv) stateNext = ST_WAIT_ACK;
        end
      end
      ST_WAIT_ACK: begin
        strobe.countAck = 1'b1;
        if (acksDone) stateNext = ST_REPLY;
      end
      ST_SEND_RECALL: begin
        outValid = 1'b1;
        msgType  = recallKind;
        if (outReady) stateNext = ST_WAIT_WB;
      end
      ST_WAIT_WB: begin
        if (wbHit) begin
          strobe.captureWb = 1'b1;
          stateNext        = ST_REPLY;
        end
      end
      ST_REPLY: begin
        outValid = 1'b1;
        if (outReady) begin
          strobe.commitShared = (replyKind == MSG_DATA_SH);
          strobe.commitExcl   = (replyKind == MSG_DATA_EX);
          stateNext           = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      replyKind  <= MSG_GRANT;
      recallKind <= MSG_RECALL_SH;
    end else begin
      state      <= stateNext;
      replyKind  <= replyNext;
      recallKind <= recallNext;
    end
  end

endmodule

// File: rtl/dir_home.sv
module dir_home
  import dir_home_pkg::*;
#(
  parameter int NUM_PROC   = 4,
  parameter int NUM_BLOCKS = 8,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = $clog2(NUM_BLOCKS),
  parameter int ID_W       = $clog2(NUM_PROC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ID_W-1:0]   reqSrc,
  input  logic              rspValid,
  input  logic              rspWb,
  input  logic [ADDR_W-1:0] rspAddr,
  input  logic [ID_W-1:0]   rspSrc,
  input  logic [DATA_W-1:0] rspData,
  output logic              outValid,
  input  logic              outReady,
  output logic [2:0]        outType,
  output logic [ADDR_W-1:0] outAddr,
  output logic [ID_W-1:0]   outDest,
  output logic [DATA_W-1:0] outData
);

  dir_strobe_t strobe;
  msg_e        msgType;
  logic        curWrite, curDirty, ownerIsReq, othersEmpty;
  logic        lastInv, acksDone, wbHit;

  dir_home_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .curWrite   (curWrite),
    .curDirty   (curDirty),
    .ownerIsReq (ownerIsReq),
    .othersEmpty(othersEmpty),
    .lastInv    (lastInv),
    .acksDone   (acksDone),
    .wbHit      (wbHit),
    .outValid   (outValid),
    .outReady   (outReady),
    .msgType    (msgType),
    .strobe     (strobe)
  );

  dir_home_dpath #(
    .NUM_PROC  (NUM_PROC),
    .NUM_BLOCKS(NUM_BLOCKS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .ID_W      (ID_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqWrite   (reqWrite),
    .reqAddr    (reqAddr),
    .reqSrc     (reqSrc),
    .rspValid   (rspValid),
    .rspWb      (rspWb),
    .rspAddr    (rspAddr),
    .rspSrc     (rspSrc),
    .rspData    (rspData),
    .msgType    (msgType),
    .outAddr    (outAddr),
    .outDest    (outDest),
    .outData    (outData),
    .curWrite   (curWrite),
    .curDirty   (curDirty),
    .ownerIsReq (ownerIsReq),
    .othersEmpty(othersEmpty),
    .lastInv    (lastInv),
    .acksDone   (acksDone),
    .wbHit      (wbHit)
  );

  assign outType = msgType;

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int ADDR_W = 3,
  parameter int ID_W   = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [ID_W-1:0]   reqSrc,
  input logic              outValid,
  input logic              outReady,
  input logic [2:0]        outType,
  input logic [ADDR_W-1:0] outAddr,
  input logic [ID_W-1:0]   outDest,
  input logic [DATA_W-1:0] outData
);

  logic [ADDR_W-1:0] seenAddr;
  logic [ID_W-1:0]   seenSrc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenAddr <= '0;
      seenSrc  <= '0;
    end else if (reqValid && reqReady) begin
      seenAddr <= reqAddr;
      seenSrc  <= reqSrc;
    end
  end

  p_stall_after_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  p_no_accept_while_sending_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !reqReady);

  p_hold_message_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outType) && $stable(outAddr)
                              && $stable(outDest) && $stable(outData));

  p_requester_not_invalidated_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outType == 3'd0 |-> outDest != seenSrc);

  p_message_address_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outAddr == seenAddr);

  p_reply_to_requester_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outType >= 3'd3 |-> outDest == seenSrc);

endmodule

bind dir_home dir_home_chk #(
  .ADDR_W(ADDR_W),
  .ID_W  (ID_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqAddr (reqAddr),
  .reqSrc  (reqSrc),
  .outValid(outValid),
  .outReady(outReady),
  .outType (outType),
  .outAddr (outAddr),
  .outDest (outDest),
  .outData (outData)
);

// File: tb/dir_home_tb.sv
module dir_home_tb;

  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid, reqReady, reqWrite;
  logic [AW-1:0] reqAddr;
  logic [IW-1:0] reqSrc;
  logic          rspValid, rspWb;
  logic [AW-1:0] rspAddr;
  logic [IW-1:0] rspSrc;
  logic [DW-1:0] rspData;
  logic          outValid, outReady;
  logic [2:0]    outType;
  logic [AW-1:0] outAddr;
  logic [IW-1:0] outDest;
  logic [DW-1:0] outData;

  dir_home #(.NUM_PROC(NP), .NUM_BLOCKS(NB), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSrc(reqSrc),
    .rspValid(rspValid), .rspWb(rspWb), .rspAddr(rspAddr),
    .rspSrc(rspSrc), .rspData(rspData),
    .outValid(outValid), .outReady(outReady), .outType(outType),
    .outAddr(outAddr), .outDest(outDest), .outData(outData)
  );

  always #5 clk = ~clk;

  int chkTotal = 0;
  int chkFail  = 0;
  bit tbBusy   = 1'b0;
  bit armed    = 1'b0;

  // Behavioural reference state
  logic [NP-1:0] mPres [NB];
  bit            mDirty [NB];
  int            mMem [NB];

  typedef struct {
    int t;
    int a;
    int d;
    int v;
  } msg_t;
  msg_t expQ[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    chkTotal++;
    if (!ok) begin
      chkFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushMsg(int t, int a, int d, int v);
    msg_t m;
    m.t = t; m.a = a; m.d = d; m.v = v;
    expQ.push_back(m);
  endtask

  // Called at a negedge; returns at a later negedge after the message is taken
  task automatic recvMsg(string req, int hold);
    msg_t e;
    int guard;
    e = expQ.pop_front();
    guard = 0;
    while (!outValid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(outValid, req, "message valid", int'(outValid), 1);
    check(int'(outType) == e.t, req, "message type", int'(outType), e.t);
    check(int'(outAddr) == e.a, req, "message address", int'(outAddr), e.a);
    check(int'(outDest) == e.d, req, "message destination", int'(outDest), e.d);
    if (e.t >= 3) check(int'(outData) == e.v, req, "reply data", int'(outData), e.v);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(outValid && int'(outType) == e.t && int'(outDest) == e.d &&
            int'(outAddr) == e.a, "R9", "held message", int'(outDest), e.d);
    end
    if (e.t >= 3) tbBusy = 1'b0;
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic sendRsp(bit wb, int a, int src, int data);
    rspValid = 1'b1;
    rspWb    = wb;
    rspAddr  = AW'(a);
    rspSrc   = IW'(src);
    rspData  = DW'(data);
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic quietCheck(string req, int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      check(!outValid, req, "no message while waiting", int'(outValid), 0);
    end
  endtask

  task automatic doReq(bit wr, int a, int src, int wbVal, bit noise, int hold, string req);
    logic [NP-1:0] mask;
    int kind;
    int owner;
    int invList[$];
    mask  = NP'(1) << src;
    owner = 0;
    for (int j = NP - 1; j >= 0; j--) if (mPres[a][j]) owner = j;
    if (mDirty[a] && mPres[a] == mask) begin
      kind = 0;
      pushMsg(5, a, src, mMem[a]);
    end else if (!mDirty[a] && !wr) begin
      kind = 0;
      pushMsg(3, a, src, mMem[a]);
    end else if (mDirty[a]) begin
      kind = 2;
      pushMsg(wr ? 2 : 1, a, owner, 0);
      pushMsg(wr ? 4 : 3, a, src, wbVal);
    end else begin
      kind = 1;
      for (int j = 0; j < NP; j++) begin
        if (mPres[a][j] && j != src) begin
          invList.push_back(j);
          pushMsg(0, a, j, 0);
        end
      end
      pushMsg(4, a, src, mMem[a]);
    end

    @(negedge clk);
    check(reqReady, "R8", "ready before request", int'(reqReady), 1);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = AW'(a);
    reqSrc   = IW'(src);
    tbBusy   = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;

    if (kind == 0) begin
      recvMsg(req, hold);
    end else if (kind == 1) begin
      for (int i = 0; i < invList.size(); i++) begin
        recvMsg("R3", (i == invList.size() - 1) ? hold : 0);
      end
      if (noise && invList.size() > 0) begin
        sendRsp(1'b0, (a + 1) % NB, invList[0], 0);
        sendRsp(1'b0, a, src, 0);
        sendRsp(1'b1, a, invList[0], 8'hEE);
      end
      foreach (invList[i]) begin
        check(!outValid, "R4", "reply before all acks", int'(outValid), 0);
        sendRsp(1'b0, a, invList[i], 0);
      end
      recvMsg("R4", 0);
    end else begin
      recvMsg(req, hold);
      if (noise) begin
        sendRsp(1'b1, a, (owner + 1) % NP, 8'hEE);
        sendRsp(1'b1, (a + 1) % NB, owner, 8'hEE);
        sendRsp(1'b0, a, owner, 0);
        quietCheck("R10", 3);
      end
      sendRsp(1'b1, a, owner, wbVal);
      recvMsg(req, 0);
    end

    if (kind == 0) begin
      if (!mDirty[a]) mPres[a] = mPres[a] | mask;
    end else if (kind == 1) begin
      mPres[a] = mask;  mDirty[a] = 1'b1;
    end else begin
      mMem[a] = wbVal;
      if (wr) begin mPres[a] = mask; mDirty[a] = 1'b1; end
      else begin mPres[a] = mPres[a] | mask; mDirty[a] = 1'b0; end
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", chkTotal, chkFail);
    $finish;
  endtask

  // Cycle-by-cycle comparison of the request handshake with the model (R8)
  always @(posedge clk) begin
    #3;
    if (armed) check(reqReady == !tbBusy, "R8", "reqReady vs model busy",
                     int'(reqReady), int'(!tbBusy));
  end

  initial begin
    #2000000;
    chkTotal++;
    chkFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqSrc = '0;
    rspValid = 1'b0; rspWb = 1'b0; rspAddr = '0; rspSrc = '0; rspData = '0;
    outReady = 1'b0;
    for (int b = 0; b < NB; b++) begin
      mPres[b] = '0; mDirty[b] = 1'b0; mMem[b] = b;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady, "R1", "reset reqReady", int'(reqReady), 1);
    check(!outValid, "R1", "reset outValid", int'(outValid), 0);
    armed = 1'b1;

    // R1 and R2: reads of a clean block return reset contents
    doReq(1'b0, 2, 1, 0, 1'b0, 0, "R1");
    doReq(1'b0, 2, 3, 0, 1'b0, 2, "R2");
    doReq(1'b0, 2, 0, 0, 1'b0, 0, "R2");
    // R3, R4, R9, R10: write with three sharers, noise acks, held invalidation
    doReq(1'b1, 2, 1, 0, 1'b1, 3, "R3");
    // R7: owner re-requests
    doReq(1'b0, 2, 1, 0, 1'b0, 0, "R7");
    doReq(1'b1, 2, 1, 0, 1'b0, 1, "R7");
    // R5 and R10: read of a modified block with a stray write-back first
    doReq(1'b0, 2, 2, 8'h5C, 1'b1, 2, "R5");
    // R5: old owner and reader are both sharers now
    doReq(1'b1, 2, 0, 0, 1'b0, 0, "R5");
    // R6: write of a modified block
    doReq(1'b1, 2, 3, 8'h77, 1'b1, 0, "R6");
    // R6: recall must now go to the new owner only
    doReq(1'b0, 2, 0, 8'h31, 1'b0, 0, "R6");
    // R4: write to an uncached block needs no invalidation
    doReq(1'b1, 5, 2, 0, 1'b0, 0, "R4");
    doReq(1'b0, 5, 2, 0, 1'b0, 0, "R7");
    // R2: another block stays independent
    doReq(1'b0, 7, 3, 0, 1'b0, 0, "R2");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2", "all expected messages seen", expQ.size(), 0);
    finishRun();
  end

endmodule